// File: doc/BRIEF.md
# Type 0 Configuration Register Target

This block is the configuration-space target of a bus interface. It watches each address phase and claims a transaction only when its select line is high, the command is a configuration read or a configuration write, and the two lowest address bits are zero. Address bits [7:2] then pick one word of a small local register file. That file has a parameterised depth, a mask of which words are present, a per-word mask of writable bits, and per-word reset values.

Writes update only the enabled byte lanes and, within those lanes, only the writable bits. Reads drive the selected word onto the data output while the output enable is high. A word index that is absent from the file, or beyond its depth, is still claimed. A write to it is dropped and a read of it returns zero, and no error is signalled. The target completes exactly one data phase per transaction. If the initiator keeps frame asserted to ask for a burst, the target signals stop together with the first ready and accepts nothing more.

Top module: `cfg0_target`

## Requirements
- R1: A write is claimed (devsel_n_o low in the cycle after the address phase) only when idsel_i is 1, cmd_i is 4'b1011 and ad_i[1:0] is 00 at the address phase. An address phase is the first cycle with frame_n_i low after a cycle with it high. Any other combination leaves devsel_n_o high and changes no register.
- R2: A read is claimed under the same rules with cmd_i equal to 4'b1010. Otherwise devsel_n_o stays high and ad_oe_o stays low.
- R3: The word is selected by ad_i[7:2] of the address phase, with word index n at byte address 4n. Reset values can be read back at their own indices.
- R4: Byte enables are active low. be_n_i[b]=0 in the data phase lets the write change bits [8b+7:8b], and lanes whose enable is 1 keep their old value.
- R5: Bits that are clear in a word's writable mask keep their reset value under any write.
- R6: For a word absent from the implemented mask, or with an index at or above the depth, the transaction is still claimed. A write to it alters no register, and a read of it returns 0.
- R7: ad_oe_o is high only while a claimed read is in its data phase. During that phase ad_o holds the selected word, including wait states in which irdy_n_i is high.
- R8: If frame_n_i is low during the data phase, stop_n_o is low together with trdy_n_o. After the first transfer, trdy_n_o goes high, stop_n_o stays low until frame_n_i goes high, and later data is not written.
- R9: If frame_n_i is high during the data phase, stop_n_o stays high. trdy_n_o is low until the transfer (irdy_n_i low), and all outputs return to idle in the next cycle.
- R10: While rst_n is low and after its release, devsel_n_o, trdy_n_o and stop_n_o are high and ad_oe_o is low. Every word holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idsel_i | input | 1 | Configuration select for this target |
| cmd_i | input | 4 | Command, sampled in the address phase |
| ad_i | input | 32 | Address in the address phase, write data in the data phase |
| be_n_i | input | 4 | Byte enables, active low, used in the data phase |
| frame_n_i | input | 1 | Transaction frame from the initiator, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| devsel_n_o | output | 1 | Transaction claimed, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| stop_n_o | output | 1 | Disconnect request, active low |
| ad_o | output | 32 | Read data |
| ad_oe_o | output | 1 | Read data output enable |

## Verification
For an address phase sampled at edge k, the claim, the target ready, the output enable and the read data all appear after edge k. They are checked at the falling edge that follows. A write lands at the first edge with irdy_n_i low after that, which is edge k+1 with no wait states. The bench therefore checks the stored value with a later read and never in the same transaction. Stop follows frame_n_i within the same data cycle, so the bench drives frame at a falling edge and samples stop a moment later. The return to idle, and the stop that is held after a burst attempt, are each checked one falling edge after the transfer edge.

// File: rtl/cfg0_pkg.sv
`timescale 1ns/1ps
package cfg0_pkg;

    localparam int IDX_W = 6;
    localparam int DW    = 32;
    localparam int LANES = DW / 8;

    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_HOLD
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e       st;
        logic             frame_prev;
        logic             is_wr;
        logic [IDX_W-1:0] idx;
    } tgt_ctrl_s;

    // expands active-low lane enables into a bit mask
    function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be_n);
        logic [DW-1:0] m;
        for (int b = 0; b < LANES; b++) begin
            m[8*b +: 8] = {8{~be_n[b]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg0_decode.sv
`timescale 1ns/1ps
module cfg0_decode
    import cfg0_pkg::*;
(
    input  logic             idsel,
    input  logic [3:0]       cmd,
    input  logic [7:0]       addr_lo,
    output logic             hit,
    output logic             is_wr,
    output logic [IDX_W-1:0] idx
);

    logic cmd_rd, cmd_wr, aligned;

    always_comb begin
        cmd_rd  = (cmd == CMD_CFG_RD);
        cmd_wr  = (cmd == CMD_CFG_WR);
        aligned = (addr_lo[1:0] == 2'b00);
        hit     = idsel && aligned && (cmd_rd || cmd_wr);
        is_wr   = cmd_wr;
        idx     = addr_lo[7:2];
    end

endmodule

// File: rtl/cfg0_ctrl.sv
`timescale 1ns/1ps
module cfg0_ctrl
    import cfg0_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             dec_hit,
    input  logic             dec_wr,
    input  logic [IDX_W-1:0] dec_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] sel_idx,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n,
    output logic             rd_oe
);

    tgt_ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.frame_prev = frame_n;
        wr_en            = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (ctl_q.frame_prev && !frame_n && dec_hit) begin
                    ctl_d.st    = ST_DATA;
                    ctl_d.is_wr = dec_wr;
                    ctl_d.idx   = dec_idx;
                end
            end
            ST_DATA: begin
                if (!irdy_n) begin
                    wr_en    = ctl_q.is_wr;
                    ctl_d.st = frame_n ? ST_IDLE : ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (frame_n) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st         <= ST_IDLE;
            ctl_q.frame_prev <= 1'b1;
            ctl_q.is_wr      <= 1'b0;
            ctl_q.idx        <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        sel_idx  = ctl_q.idx;
        devsel_n = !((ctl_q.st == ST_DATA) || (ctl_q.st == ST_HOLD));
        trdy_n   = !(ctl_q.st == ST_DATA);
        stop_n   = !(((ctl_q.st == ST_DATA) && !frame_n) || (ctl_q.st == ST_HOLD));
        rd_oe    = (ctl_q.st == ST_DATA) && !ctl_q.is_wr;
    end

endmodule

// File: rtl/cfg0_regs.sv
`timescale 1ns/1ps
module cfg0_regs
    import cfg0_pkg::*;
#(
    parameter int                     NUM_REGS  = 8,
    parameter logic [NUM_REGS-1:0]    IMPL_MASK = '1,
    parameter logic [NUM_REGS*DW-1:0] WR_MASK   = '1,
    parameter logic [NUM_REGS*DW-1:0] RST_VAL   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [LANES-1:0] wr_be_n,
    output logic [DW-1:0]    rd_data
);

    logic [DW-1:0] words [NUM_REGS];
    logic [DW-1:0] be_mask;

    always_comb be_mask = lane_mask(wr_be_n);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        if (IMPL_MASK[g]) begin : g_impl
            logic [DW-1:0] word_d, word_q;
            logic [DW-1:0] eff_mask;

            always_comb begin
                eff_mask = be_mask & WR_MASK[g*DW +: DW];
                word_d   = word_q;
                if (wr_en && (idx == IDX_W'(g))) begin
                    word_d = (word_q & ~eff_mask) | (wr_data & eff_mask);
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) word_q <= RST_VAL[g*DW +: DW];
                else        word_q <= word_d;
            end

            assign words[g] = word_q;
        end else begin : g_absent
            assign words[g] = '0;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (idx == IDX_W'(i)) rd_data = words[i];
        end
    end

endmodule

// File: rtl/cfg0_target.sv
`timescale 1ns/1ps
module cfg0_target
    import cfg0_pkg::*;
#(
    parameter int                     NUM_REGS  = 8,
    parameter logic [NUM_REGS-1:0]    IMPL_MASK = 8'b1011_0111,
    parameter logic [NUM_REGS*DW-1:0] WR_MASK   = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFF00_FF00, 32'hFFFF_FFFF,
                                                   32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_0000},
    parameter logic [NUM_REGS*DW-1:0] RST_VAL   = {32'h0000_0000, 32'h0000_0000, 32'h0012_0034, 32'h0000_0000,
                                                   32'h7777_7777, 32'hA5A5_0000, 32'h0000_0000, 32'hC0DE_1234}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        idsel_i,
    input  logic [3:0]  cmd_i,
    input  logic [31:0] ad_i,
    input  logic [3:0]  be_n_i,
    input  logic        frame_n_i,
    input  logic        irdy_n_i,
    output logic        devsel_n_o,
    output logic        trdy_n_o,
    output logic        stop_n_o,
    output logic [31:0] ad_o,
    output logic        ad_oe_o
);

    logic             dec_hit, dec_wr;
    logic [IDX_W-1:0] dec_idx, sel_idx;
    logic             wr_en, rd_oe;
    logic [DW-1:0]    rd_data;

    cfg0_decode u_decode (
        .idsel   (idsel_i),
        .cmd     (cmd_i),
        .addr_lo (ad_i[7:0]),
        .hit     (dec_hit),
        .is_wr   (dec_wr),
        .idx     (dec_idx)
    );

    cfg0_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n_i),
        .irdy_n   (irdy_n_i),
        .dec_hit  (dec_hit),
        .dec_wr   (dec_wr),
        .dec_idx  (dec_idx),
        .wr_en    (wr_en),
        .sel_idx  (sel_idx),
        .devsel_n (devsel_n_o),
        .trdy_n   (trdy_n_o),
        .stop_n   (stop_n_o),
        .rd_oe    (rd_oe)
    );

    cfg0_regs #(
        .NUM_REGS  (NUM_REGS),
        .IMPL_MASK (IMPL_MASK),
        .WR_MASK   (WR_MASK),
        .RST_VAL   (RST_VAL)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .idx     (sel_idx),
        .wr_data (ad_i),
        .wr_be_n (be_n_i),
        .rd_data (rd_data)
    );

    always_comb begin
        ad_oe_o = rd_oe;
        ad_o    = rd_oe ? rd_data : '0;
    end

endmodule

// File: rtl/cfg0_target_chk.sv
`timescale 1ns/1ps
module cfg0_target_chk (
    input logic clk,
    input logic rst_n,
    input logic idsel_i,
    input logic frame_n_i,
    input logic irdy_n_i,
    input logic devsel_n_o,
    input logic trdy_n_o,
    input logic stop_n_o,
    input logic ad_oe_o
);

    assert_unselected_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n_i) && !idsel_i) |=> devsel_n_o);

    assert_ready_only_when_claimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n_o |-> !devsel_n_o);

    assert_oe_only_in_read_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> (!devsel_n_o && !trdy_n_o));

    assert_burst_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n_o && !frame_n_i) |-> !stop_n_o);

    assert_single_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n_o && !irdy_n_i) |=> trdy_n_o);

    assert_no_stop_on_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n_o && frame_n_i) |-> stop_n_o);

    assert_stop_needs_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n_o |-> !devsel_n_o);

endmodule

bind cfg0_target cfg0_target_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .idsel_i    (idsel_i),
    .frame_n_i  (frame_n_i),
    .irdy_n_i   (irdy_n_i),
    .devsel_n_o (devsel_n_o),
    .trdy_n_o   (trdy_n_o),
    .stop_n_o   (stop_n_o),
    .ad_oe_o    (ad_oe_o)
);

// File: tb/cfg0_target_tb_top.sv
`timescale 1ns/1ps
module cfg0_target_tb_top;

    localparam int                 NREG = 8;
    localparam logic [NREG-1:0]    T_IMPL = 8'b1011_0111;
    localparam logic [NREG*32-1:0] T_WMASK = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFF00_FF00, 32'hFFFF_FFFF,
                                              32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h0000_0000};
    localparam logic [NREG*32-1:0] T_RST   = {32'h0000_0000, 32'h0000_0000, 32'h0012_0034, 32'h0000_0000,
                                              32'h7777_7777, 32'hA5A5_0000, 32'h0000_0000, 32'hC0DE_1234};

    typedef struct packed {
        logic        idsel;
        logic [3:0]  cmd;
        logic [7:0]  addr;
        logic [3:0]  be_n;
        logic [31:0] wdata;
        logic        claim;
        logic [31:0] rdata;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'hA, 8'h00, 4'hF, 32'h0,         1'b1, 32'hC0DE_1234, 4'd10},
        '{1'b1, 4'hA, 8'h08, 4'hF, 32'h0,         1'b1, 32'hA5A5_0000, 4'd3},
        '{1'b1, 4'hB, 8'h04, 4'h0, 32'h1122_3344, 1'b1, 32'h0,         4'd1},
        '{1'b1, 4'hA, 8'h04, 4'hF, 32'h0,         1'b1, 32'h1122_3344, 4'd2},
        '{1'b1, 4'hB, 8'h04, 4'hA, 32'hAABB_CCDD, 1'b1, 32'h0,         4'd4},
        '{1'b1, 4'hA, 8'h04, 4'hF, 32'h0,         1'b1, 32'h11BB_33DD, 4'd4},
        '{1'b0, 4'hB, 8'h04, 4'h0, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd1},
        '{1'b1, 4'hB, 8'h05, 4'h0, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd1},
        '{1'b1, 4'hB, 8'h06, 4'h0, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd1},
        '{1'b1, 4'h7, 8'h04, 4'h0, 32'hFFFF_FFFF, 1'b0, 32'h0,         4'd1},
        '{1'b0, 4'hA, 8'h04, 4'hF, 32'h0,         1'b0, 32'h0,         4'd2},
        '{1'b1, 4'hA, 8'h07, 4'hF, 32'h0,         1'b0, 32'h0,         4'd2},
        '{1'b1, 4'h6, 8'h04, 4'hF, 32'h0,         1'b0, 32'h0,         4'd2},
        '{1'b1, 4'hA, 8'h04, 4'hF, 32'h0,         1'b1, 32'h11BB_33DD, 4'd1},
        '{1'b1, 4'hB, 8'h00, 4'h0, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd5},
        '{1'b1, 4'hA, 8'h00, 4'hF, 32'h0,         1'b1, 32'hC0DE_1234, 4'd5},
        '{1'b1, 4'hB, 8'h08, 4'h0, 32'h1234_5678, 1'b1, 32'h0,         4'd5},
        '{1'b1, 4'hA, 8'h08, 4'hF, 32'h0,         1'b1, 32'hA5A5_5678, 4'd5},
        '{1'b1, 4'hB, 8'h0C, 4'h0, 32'hDEAD_BEEF, 1'b1, 32'h0,         4'd6},
        '{1'b1, 4'hA, 8'h0C, 4'hF, 32'h0,         1'b1, 32'h0,         4'd6},
        '{1'b1, 4'hA, 8'h3C, 4'hF, 32'h0,         1'b1, 32'h0,         4'd6},
        '{1'b1, 4'hB, 8'hFC, 4'h0, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd6},
        '{1'b1, 4'hB, 8'h14, 4'h3, 32'hFFFF_FFFF, 1'b1, 32'h0,         4'd4},
        '{1'b1, 4'hA, 8'h14, 4'hF, 32'h0,         1'b1, 32'hFF12_0034, 4'd4},
        '{1'b1, 4'hA, 8'h1C, 4'hF, 32'h0,         1'b1, 32'h0,         4'd6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idsel_i = 1'b0;
    logic [3:0]  cmd_i = 4'h0;
    logic [31:0] ad_i = '0;
    logic [3:0]  be_n_i = 4'hF;
    logic        frame_n_i = 1'b1;
    logic        irdy_n_i = 1'b1;
    logic        devsel_n_o, trdy_n_o, stop_n_o, ad_oe_o;
    logic [31:0] ad_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cfg0_target #(
        .NUM_REGS  (NREG),
        .IMPL_MASK (T_IMPL),
        .WR_MASK   (T_WMASK),
        .RST_VAL   (T_RST)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idsel_i    (idsel_i),
        .cmd_i      (cmd_i),
        .ad_i       (ad_i),
        .be_n_i     (be_n_i),
        .frame_n_i  (frame_n_i),
        .irdy_n_i   (irdy_n_i),
        .devsel_n_o (devsel_n_o),
        .trdy_n_o   (trdy_n_o),
        .stop_n_o   (stop_n_o),
        .ad_o       (ad_o),
        .ad_oe_o    (ad_oe_o)
    );

    function automatic string tag(input logic [3:0] n);
        case (n)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // address phase at the next falling edge
    task automatic addr_phase(input logic sel, input logic [3:0] cmd, input logic [7:0] addr);
        @(negedge clk);
        frame_n_i = 1'b0;
        irdy_n_i  = 1'b1;
        idsel_i   = sel;
        cmd_i     = cmd;
        ad_i      = {24'h0, addr};
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R10: idle outputs during and after reset
        repeat (3) @(negedge clk);
        chk("R10", {28'h0, devsel_n_o, trdy_n_o, stop_n_o, ad_oe_o}, 32'hE);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", {28'h0, devsel_n_o, trdy_n_o, stop_n_o, ad_oe_o}, 32'hE);

        // table walk: one single-phase transaction per entry
        for (int i = 0; i < NV; i++) begin
            addr_phase(VECS[i].idsel, VECS[i].cmd, VECS[i].addr);
            @(negedge clk);
            frame_n_i = 1'b1;
            irdy_n_i  = 1'b0;
            idsel_i   = 1'b0;
            ad_i      = VECS[i].wdata;
            be_n_i    = VECS[i].be_n;
            #0.5;
            chk(tag(VECS[i].req), {31'h0, ~devsel_n_o}, {31'h0, VECS[i].claim});
            chk("R7", {31'h0, ad_oe_o}, {31'h0, VECS[i].claim && (VECS[i].cmd == 4'hA)});
            chk("R9", {30'h0, ~trdy_n_o, ~stop_n_o}, {30'h0, VECS[i].claim, 1'b0});
            if (VECS[i].claim && VECS[i].cmd == 4'hA)
                chk(tag(VECS[i].req), ad_o, VECS[i].rdata);
            @(negedge clk);
            irdy_n_i = 1'b1;
            be_n_i   = 4'hF;
            ad_i     = '0;
            #0.5;
            chk("R9", {29'h0, devsel_n_o, trdy_n_o, ad_oe_o}, 32'h6);
        end

        // R8: burst attempt to word 7, second phase must not land
        addr_phase(1'b1, 4'hB, 8'h1C);
        @(negedge clk);
        frame_n_i = 1'b0;
        irdy_n_i  = 1'b0;
        idsel_i   = 1'b0;
        ad_i      = 32'h0101_0101;
        be_n_i    = 4'h0;
        #0.5;
        chk("R8", {29'h0, devsel_n_o, trdy_n_o, stop_n_o}, 32'h0);
        @(negedge clk);
        ad_i = 32'h0202_0202;
        #0.5;
        chk("R8", {29'h0, devsel_n_o, trdy_n_o, stop_n_o}, 32'h2);
        @(negedge clk);
        #0.5;
        chk("R8", {29'h0, devsel_n_o, trdy_n_o, stop_n_o}, 32'h2);
        frame_n_i = 1'b1;
        @(negedge clk);
        irdy_n_i = 1'b1;
        be_n_i   = 4'hF;
        ad_i     = '0;
        #0.5;
        chk("R8", {29'h0, devsel_n_o, trdy_n_o, stop_n_o}, 32'h7);

        // read back word 7: only the first phase was written (R8)
        addr_phase(1'b1, 4'hA, 8'h1C);
        @(negedge clk);
        frame_n_i = 1'b1;
        irdy_n_i  = 1'b0;
        idsel_i   = 1'b0;
        #0.5;
        chk("R8", ad_o, 32'h0101_0101);
        @(negedge clk);
        irdy_n_i = 1'b1;

        // R7: read with initiator wait states keeps data on the output
        addr_phase(1'b1, 4'hA, 8'h08);
        @(negedge clk);
        frame_n_i = 1'b1;
        irdy_n_i  = 1'b1;
        idsel_i   = 1'b0;
        #0.5;
        chk("R7", {31'h0, ad_oe_o}, 32'h1);
        chk("R7", ad_o, 32'hA5A5_5678);
        @(negedge clk);
        #0.5;
        chk("R7", {30'h0, ad_oe_o, trdy_n_o}, 32'h2);
        chk("R7", ad_o, 32'hA5A5_5678);
        @(negedge clk);
        irdy_n_i = 1'b0;
        #0.5;
        chk("R7", ad_o, 32'hA5A5_5678);
        @(negedge clk);
        irdy_n_i = 1'b1;
        #0.5;
        chk("R9", {30'h0, devsel_n_o, ad_oe_o}, 32'h2);

        finish_run();
    end

endmodule